// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register side of a power-management companion chip. A serial bus slave decodes each transfer and presents it here as a 5-bit register index with a read or a write strobe and 16-bit data. The block holds 32 register slots. Among them are an interrupt status word with an interrupt mask, an ADC channel selector that reads back a fixed table of conversion results, and a sample-control word that software clears bit by bit. It also holds two general control words, a clock-calibration word, a status word that follows the power key, and a watchdog slot that can ask the system to power down.

A power-key event input raises an interrupt and updates the key-state bit of the status word. The interrupt output stays high while any unmasked status bit is set. Conversions and time counting are not modelled. The ADC results are fixed constants, and the clock registers read as zero.

Top module: `pmic_regfile`

## Requirements
- R1: After reset the interrupt mask (index 0x02) reads 0xFFFF, the interrupt status (index 0x01) reads 0x0000, the status word (index 0x16) reads 0x0020, the calibration word (index 0x06) reads 0x0001, and `irq`, `shutdown_req` and `bad_idx` are 0.
- R2: `irq` is 1 exactly when some bit is 1 in the interrupt status and 0 in the mask. A mask bit of 1 blocks its source. The mask is read/write at index 0x02.
- R3: A write to index 0x01 XORs `wdata` into the interrupt status. A read of index 0x01 returns the raw status.
- R4: Index 0x00 is read-only and reads 0x0215, with bit 7 also set when parameter `VARIANT` is 1.
- R5: A write to index 0x08 latches `wdata[13:10]` as the ADC channel and sets interrupt status bit 8. A read of index 0x08 returns the channel in bits 13:10, ORed with that channel's 10-bit result. Non-zero results: ch1=0x3C2, ch2=0x0FC, ch3=0x165, ch4=0x07B, ch5=0x3FF, ch6=0x011, ch7=0x011, ch8=0x250, ch10=0x002, ch11=0x011, ch12=0x3D0, ch13=0x330. All other channels read 0.
- R6: The sample-control word at index 0x09 resets to `SAMPLE_INIT` (default 0x00FF). A write to it clears every bit that is 1 in `wdata` and leaves the other bits unchanged.
- R7: A write of 0x0000 to index 0x17 gives a one-cycle `shutdown_req` pulse in the cycle after the write, but only when bit 1 of the control word at index 0x0D is 1. A non-zero write gives no pulse.
- R8: A `key_evt` pulse sets interrupt status bit 0. It sets status word bit 5 to the inverse of `key_down`: bit 5 is 0 while the key is pressed and 1 once it is released.
- R9: The calibration word (0x06) and the control words (0x0D, 0x0E) are plain 16-bit read/write registers.
- R10: These indices are valid but have no storage: 0x03–0x05, 0x0A–0x0C, 0x0F–0x11 and 0x18–0x1F. They read 0 and ignore writes, and so do writes to the read-only 0x00 and 0x16. Indices 0x07 and 0x12–0x15 are out of the map. They read 0, and any access to them pulses `bad_idx` for one cycle, in the cycle after the access.
- R11: When `key_evt` and a write to index 0x01 fall in the same cycle, status bit 0 ends up 1 whatever was written. The other bits still toggle.
- R12: `rdata` is registered. It shows the value read in the cycle after `rd_en`. That value is the register state before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx | input | 5 | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| key_evt | input | 1 | Power-key event pulse |
| key_down | input | 1 | Key level sampled with `key_evt` (1 = pressed) |
| irq | output | 1 | Interrupt request |
| shutdown_req | output | 1 | One-cycle power-down request |
| bad_idx | output | 1 | One-cycle out-of-map access flag |

## Verification
The power-key event and a bus write to the interrupt status register can both change status bit 0 in the same clock. The bench first sets bit 0 with a key event. It then drives a second `key_evt` in the same cycle as a write of 0x0003 to index 0x01. A toggle alone would clear bit 0, so the later read of the status register must show bit 0 still set and bit 1 flipped. The bench's reference model applies the event after the toggle to give the expected value.

// File: rtl/pmic_regfile.sv
module pmic_regfile #(
  parameter int          VARIANT     = 0,
  parameter logic [15:0] SAMPLE_INIT = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  idx,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        key_evt,
  input  logic        key_down,
  output logic        irq,
  output logic        shutdown_req,
  output logic        bad_idx
);
  localparam logic [4:0] IX_ID   = 5'h00;
  localparam logic [4:0] IX_IST  = 5'h01;
  localparam logic [4:0] IX_MSK  = 5'h02;
  localparam logic [4:0] IX_CAL  = 5'h06;
  localparam logic [4:0] IX_ADC  = 5'h08;
  localparam logic [4:0] IX_SMP  = 5'h09;
  localparam logic [4:0] IX_CT1  = 5'h0D;
  localparam logic [4:0] IX_CT2  = 5'h0E;
  localparam logic [4:0] IX_STS  = 5'h16;
  localparam logic [4:0] IX_WDG  = 5'h17;
  localparam logic [15:0] ID_VAL = 16'h0215 | (VARIANT == 1 ? 16'h0080 : 16'h0000);

  logic [15:0] ist, msk, cal, ct1, ct2, smp;
  logic [3:0]  chan;
  logic        key_up;
  logic [15:0] rd_val, ist_nx;
  logic        in_map;

  function automatic logic [9:0] adc_res(input logic [3:0] c);
    case (c)
      4'd1:    adc_res = 10'h3C2;
      4'd2:    adc_res = 10'h0FC;
      4'd3:    adc_res = 10'h165;
      4'd4:    adc_res = 10'h07B;
      4'd5:    adc_res = 10'h3FF;
      4'd6:    adc_res = 10'h011;
      4'd7:    adc_res = 10'h011;
      4'd8:    adc_res = 10'h250;
      4'd10:   adc_res = 10'h002;
      4'd11:   adc_res = 10'h011;
      4'd12:   adc_res = 10'h3D0;
      4'd13:   adc_res = 10'h330;
      default: adc_res = 10'h000;
    endcase
  endfunction

  assign in_map = !(idx == 5'h07 || (idx >= 5'h12 && idx <= 5'h15));
  assign irq    = |(ist & ~msk);

  always_comb begin
    ist_nx = ist;
    if (wr_en && idx == IX_IST) ist_nx = ist_nx ^ wdata;
    if (wr_en && idx == IX_ADC) ist_nx[8] = 1'b1;
    if (key_evt)                ist_nx[0] = 1'b1;
  end

  always_comb begin
    case (idx)
      IX_ID:   rd_val = ID_VAL;
      IX_IST:  rd_val = ist;
      IX_MSK:  rd_val = msk;
      IX_CAL:  rd_val = cal;
      IX_ADC:  rd_val = {2'b00, chan, adc_res(chan)};
      IX_SMP:  rd_val = smp;
      IX_CT1:  rd_val = ct1;
      IX_CT2:  rd_val = ct2;
      IX_STS:  rd_val = {10'd0, key_up, 5'd0};
      default: rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist <= 16'h0000;
      msk <= 16'hFFFF;
      cal <= 16'h0001;
      ct1 <= 16'h0000;
      ct2 <= 16'h0000;
      smp <= SAMPLE_INIT;
      chan <= 4'd0;
      key_up <= 1'b1;
      rdata <= 16'h0000;
      shutdown_req <= 1'b0;
      bad_idx <= 1'b0;
    end else begin
      ist <= ist_nx;
      if (rd_en) rdata <= rd_val;
      shutdown_req <= wr_en && idx == IX_WDG && wdata == 16'h0000 && ct1[1];
      bad_idx <= (wr_en || rd_en) && !in_map;
      if (key_evt) key_up <= !key_down;
      if (wr_en) begin
        case (idx)
          IX_MSK: msk <= wdata;
          IX_CAL: cal <= wdata;
          IX_ADC: chan <= wdata[13:10];
          IX_SMP: smp <= smp & ~wdata;
          IX_CT1: ct1 <= wdata;
          IX_CT2: ct2 <= wdata;
          default: ;
        endcase
      end
    end
  end

  AST_IST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_IST && !key_evt) |=> (ist == ($past(ist) ^ $past(wdata)))); // R3
  AST_ADC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_ADC) |=> ist[8]); // R5
  AST_SMP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_SMP) |=> ((smp & $past(wdata)) == 16'h0000)); // R6
  AST_SHUTDOWN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_en && idx == IX_WDG && wdata == 16'h0000 && ct1[1])); // R7
  AST_SHUTDOWN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req); // R7
  AST_KEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt |=> ist[0]); // R8 R11
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_MSK && wdata == 16'hFFFF) |=> !irq); // R2
  AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx |-> $past((wr_en || rd_en) && !in_map)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R12
endmodule

// File: tb/pmic_regfile_tb.sv
module pmic_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  idx = 5'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        key_evt = 1'b0, key_down = 1'b0;
  logic        irq, shutdown_req, bad_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic rd_d = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] ist_m = 16'h0000;

  always #2 clk = ~clk;

  pmic_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .key_evt(key_evt), .key_down(key_down),
    .irq(irq), .shutdown_req(shutdown_req), .bad_idx(bad_idx)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rd_d <= rd_en;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: unexpected read result actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [4:0] i, input logic [15:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr_en = 1'b1;
    if (i == 5'h01) ist_m = ist_m ^ d;
    if (i == 5'h08) ist_m[8] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] i, input logic [15:0] exp, input string tag);
    @(negedge clk);
    idx = i; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic key(input logic down);
    @(negedge clk);
    key_evt = 1'b1; key_down = down;
    ist_m[0] = 1'b1;
    @(negedge clk);
    key_evt = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 shutdown", {15'd0, shutdown_req}, 16'h0);
    check("R1 bad_idx", {15'd0, bad_idx}, 16'h0);
    rd(5'h02, 16'hFFFF, "R1 mask");
    rd(5'h01, 16'h0000, "R1 status");
    rd(5'h16, 16'h0020, "R1 key word");
    rd(5'h06, 16'h0001, "R1 cal");
    rd(5'h00, 16'h0215, "R4 id");
    wr(5'h00, 16'hFFFF);
    rd(5'h00, 16'h0215, "R10 id read-only");

    wr(5'h01, 16'h0005);
    check("R2 masked irq", {15'd0, irq}, 16'h0);
    wr(5'h02, 16'h0000);
    check("R2 unmasked irq", {15'd0, irq}, 16'h1);
    rd(5'h01, ist_m, "R3 toggle set");
    wr(5'h01, 16'h0004);
    rd(5'h01, ist_m, "R3 toggle clear");
    wr(5'h02, 16'h0001);
    check("R2 bit0 masked", {15'd0, irq}, 16'h0);
    wr(5'h02, 16'hFFFE);
    check("R2 bit0 open", {15'd0, irq}, 16'h1);
    rd(5'h02, 16'hFFFE, "R2 mask readback");
    wr(5'h01, 16'h0001);
    check("R3 cleared irq", {15'd0, irq}, 16'h0);

    wr(5'h08, 16'd5 << 10);
    rd(5'h01, 16'h0100, "R5 adc done bit");
    rd(5'h08, 16'h17FF, "R5 ch5");
    wr(5'h08, 16'd13 << 10);
    rd(5'h08, 16'h3730, "R5 ch13");
    wr(5'h08, 16'd9 << 10);
    rd(5'h08, 16'h2400, "R5 ch9 empty");
    wr(5'h08, (16'd1 << 10) | 16'h03FF);
    rd(5'h08, 16'h07C2, "R5 ch1 low bits ignored");
    wr(5'h01, ist_m);

    rd(5'h09, 16'h00FF, "R6 sample reset");
    wr(5'h09, 16'h000F);
    rd(5'h09, 16'h00F0, "R6 w1c");
    wr(5'h09, 16'hFF00);
    rd(5'h09, 16'h00F0, "R6 zeros kept");

    wr(5'h06, 16'h1234);
    wr(5'h0E, 16'hBEEF);
    rd(5'h06, 16'h1234, "R9 cal");
    rd(5'h0E, 16'hBEEF, "R9 ctl2");

    wr(5'h17, 16'h0000);
    check("R7 gated off", {15'd0, shutdown_req}, 16'h0);
    wr(5'h0D, 16'h0002);
    rd(5'h0D, 16'h0002, "R9 ctl1");
    wr(5'h17, 16'h0005);
    check("R7 nonzero", {15'd0, shutdown_req}, 16'h0);
    wr(5'h17, 16'h0000);
    check("R7 pulse", {15'd0, shutdown_req}, 16'h1);
    @(negedge clk);
    check("R7 one cycle", {15'd0, shutdown_req}, 16'h0);

    key(1'b1);
    rd(5'h16, 16'h0000, "R8 pressed");
    rd(5'h01, ist_m, "R8 key interrupt");
    key(1'b0);
    rd(5'h16, 16'h0020, "R8 released");

    wr(5'h03, 16'hFFFF);
    rd(5'h03, 16'h0000, "R10 unimplemented");
    rd(5'h0A, 16'h0000, "R10 unimplemented read");
    wr(5'h16, 16'h0000);
    rd(5'h16, 16'h0020, "R10 status read-only");
    wr(5'h07, 16'h1111);
    check("R10 bad write flag", {15'd0, bad_idx}, 16'h1);
    @(negedge clk);
    check("R10 flag one cycle", {15'd0, bad_idx}, 16'h0);
    rd(5'h12, 16'h0000, "R10 out of map read");
    check("R10 bad read flag", {15'd0, bad_idx}, 16'h1);

    @(negedge clk);
    idx = 5'h01; wdata = 16'h0003; wr_en = 1'b1; key_evt = 1'b1; key_down = 1'b0;
    ist_m = ist_m ^ 16'h0003;
    ist_m[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; key_evt = 1'b0;
    rd(5'h01, ist_m, "R11 event beats toggle");

    @(negedge clk);
    idx = 5'h06; wdata = 16'h5555; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(16'h1234); tag_q.push_back("R12 read before write");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(5'h06, 16'h5555, "R12 write landed");

    repeat (3) @(negedge clk);
    check("R12 queue drained", 16'(exp_q.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule